// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block is the control engine for a single DMA channel. A start pulse gives it the address of a first descriptor. It reads the four words of that descriptor through a simple read port and decodes the unit width, the two address increments and the unit count. From these it works out the starting addresses, because each descriptor stores the address of the last unit rather than the first. It then hands one unit transfer at a time to an external data mover through a go/done handshake.

When the last unit of a descriptor is done, the block can raise one of two completion pulses. It then either stops or, if the descriptor asks for a reload, fetches the descriptor at the link address and continues.

Status outputs show whether the channel is busy, how many units of the current descriptor are still to be moved, and whether a descriptor was rejected for misalignment. An abort input brings the channel back to idle without cutting a unit transfer in half.

Top module: `dma_chain_seq`

## Requirements
- R1: After a start pulse is accepted in idle, the block reads four words at byte addresses A, A+4, A+8 and A+12, where A is the start address. The words are taken in this order: configuration, last source address, last destination address, link address.
- R2: Configuration bit 0 is the valid flag. A descriptor with this bit clear ends the chain: no unit is issued, the error flag stays low and the channel goes inactive.
- R3: Configuration bits 25:16 hold the unit count minus one, so a descriptor moves 1 to 1024 units. The remaining output equals the full count when the first unit is issued. It drops by one at each completed unit and never exceeds 1024.
- R4: Configuration bits 5:4 select the unit width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. This code is driven on the size output. Bits 7:6 set the source increment and bits 9:8 the destination increment: 0 means a fixed address, and 1, 2 and 3 mean steps of 1, 2 and 4 units.
- R5: Each address advances by its increment times the width. The first unit uses the stored last address minus (count−1)×increment×width. The last unit uses the stored last address itself.
- R6: Once go is raised, it stays high with stable addresses until done is returned. One unit completes per go/done pair.
- R7: If configuration bit 1 (reload) is set, the descriptor at the link address is fetched after the last unit completes. If it is clear, the channel goes inactive.
- R8: Configuration bit 2 enables a one-cycle pulse on irq_a, and bit 3 a one-cycle pulse on irq_b. The pulse is raised in the cycle after the last unit of that descriptor completes.
- R9: Width code 3, or a last source or destination address not aligned to the width, sets the error flag. The channel goes inactive and no unit of that descriptor is issued. The flag holds until err_clr is pulsed.
- R10: Abort during a descriptor fetch or decode makes the channel inactive on the next cycle. Abort while a unit is in flight makes the channel inactive in the cycle after that unit's done. No further unit is issued, no interrupt is raised, and remaining keeps the count of units not moved.
- R11: active is high from the accepted start until the chain ends. The read request and go are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain (taken only when idle) |
| start_addr | input | AW | Byte address of the first descriptor |
| abort | input | 1 | Stop the chain at the next safe point |
| err_clr | input | 1 | Clear the error flag |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid for the current request |
| mem_rdata | input | 32 | Read data |
| mv_go | output | 1 | Unit transfer request to the data mover |
| mv_src | output | AW | Source address of the unit |
| mv_dst | output | AW | Destination address of the unit |
| mv_size | output | 2 | Unit width code |
| mv_done | input | 1 | Data mover finished the unit |
| remaining | output | CW+1 | Units of the current descriptor not yet moved |
| active | output | 1 | Channel busy |
| err | output | 1 | Address error flag |
| irq_a | output | 1 | Completion pulse A |
| irq_b | output | 1 | Completion pulse B |

## Verification
With a read port that answers in the same cycle, the four fetch cycles and one decode cycle put the first go five cycles after start is sampled. The bench's mover returns done one cycle after it sees go, so each unit takes two cycles. Registers such as remaining, irq_a and irq_b, and active change on the same edge as the done that causes them. The bench therefore logs each unit at the clock edge where go and done are both high, and reads the status outputs on the following falling edge. Waits for idle are bounded by a cycle count. The abort case is timed so that exactly one more unit must complete after abort, which fixes the expected unit count and remaining value.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          abort,
  input  logic          err_clr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          mv_go,
  output logic [AW-1:0] mv_src,
  output logic [AW-1:0] mv_dst,
  output logic [1:0]    mv_size,
  input  logic          mv_done,
  output logic [CW:0]   remaining,
  output logic          active,
  output logic          err,
  output logic          irq_a,
  output logic          irq_b
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EVAL, S_MOVE} st_t;

  st_t           st;
  logic [1:0]    widx;
  logic [31:0]   cfg;
  logic [AW-1:0] dptr, send, dend, link, src, dst;
  logic          abort_pend;

  wire          f_valid  = cfg[0];
  wire          f_reload = cfg[1];
  wire          f_ia     = cfg[2];
  wire          f_ib     = cfg[3];
  wire [1:0]    wsz      = cfg[5:4];
  wire [1:0]    sic      = cfg[7:6];
  wire [1:0]    dic      = cfg[9:8];
  wire [CW-1:0] cm1      = cfg[16 +: CW];

  wire [2:0] ssh = {1'b0, sic} - 3'd1 + {1'b0, wsz};
  wire [2:0] dsh = {1'b0, dic} - 3'd1 + {1'b0, wsz};

  wire [AW-1:0] sstep = (sic == 2'd0) ? '0 : (AW'(1) << ssh);
  wire [AW-1:0] dstep = (dic == 2'd0) ? '0 : (AW'(1) << dsh);
  wire [AW-1:0] sspan = (sic == 2'd0) ? '0 : (AW'(cm1) << ssh);
  wire [AW-1:0] dspan = (dic == 2'd0) ? '0 : (AW'(cm1) << dsh);

  wire misalign = (wsz == 2'd3) ||
                  (wsz == 2'd1 && (send[0] || dend[0])) ||
                  (wsz == 2'd2 && ((|send[1:0]) || (|dend[1:0])));

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = dptr + {{(AW-4){1'b0}}, widx, 2'b00};
  assign mv_go    = (st == S_MOVE);
  assign mv_src   = src;
  assign mv_dst   = dst;
  assign mv_size  = wsz;
  assign active   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; cfg <= '0; dptr <= '0;
      send <= '0; dend <= '0; link <= '0; src <= '0; dst <= '0;
      remaining <= '0; err <= 1'b0; irq_a <= 1'b0; irq_b <= 1'b0;
      abort_pend <= 1'b0;
    end else begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
      if (err_clr) err <= 1'b0;
      unique case (st)
        S_IDLE: if (start && !abort) begin
          dptr <= start_addr; widx <= '0; st <= S_FETCH;
        end
        S_FETCH: if (abort) st <= S_IDLE;
        else if (mem_rvalid) begin
          unique case (widx)
            2'd0: cfg  <= mem_rdata;
            2'd1: send <= AW'(mem_rdata);
            2'd2: dend <= AW'(mem_rdata);
            default: link <= AW'(mem_rdata);
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) st <= S_EVAL;
        end
        S_EVAL: if (abort || !f_valid) begin
          st <= S_IDLE; remaining <= '0;
        end else if (misalign) begin
          st <= S_IDLE; remaining <= '0; err <= 1'b1;
        end else begin
          src <= send - sspan; dst <= dend - dspan;
          remaining <= {1'b0, cm1} + 1'b1;
          abort_pend <= 1'b0;
          st <= S_MOVE;
        end
        default: begin
          if (abort) abort_pend <= 1'b1;
          if (mv_done) begin
            src <= src + sstep; dst <= dst + dstep;
            remaining <= remaining - 1'b1;
            if (abort || abort_pend) begin
              abort_pend <= 1'b0; st <= S_IDLE;
            end else if (remaining == 1) begin
              irq_a <= f_ia; irq_b <= f_ib;
              if (f_reload) begin
                dptr <= link; widx <= '0; st <= S_FETCH;
              end else st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          mem_req,
  input logic          mv_go,
  input logic [AW-1:0] mv_src,
  input logic [AW-1:0] mv_dst,
  input logic [1:0]    mv_size,
  input logic          mv_done,
  input logic [CW:0]   remaining,
  input logic          active,
  input logic          err,
  input logic          irq_a,
  input logic          irq_b
);
  assert_go_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mv_go && !mv_done |=> mv_go && $stable(mv_src) && $stable(mv_dst));

  assert_rem_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_go && mv_done |=> remaining == $past(remaining) - 1'b1);

  assert_rem_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= (CW+1)'(1 << CW));

  assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_go |-> mv_size != 2'd3);

  assert_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mv_go && mv_size == 2'd2 |-> mv_src[1:0] == 2'b00 && mv_dst[1:0] == 2'b00);

  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !active);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a || irq_b) |=> !irq_a && !irq_b);

  assert_abort_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort && active && !mv_go |=> !active);

  assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mv_go));
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .mem_req(mem_req), .mv_go(mv_go),
  .mv_src(mv_src), .mv_dst(mv_dst), .mv_size(mv_size), .mv_done(mv_done),
  .remaining(remaining), .active(active), .err(err), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0, err_clr = 1'b0;
  logic [31:0] start_addr = '0;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        mv_go, mv_done = 1'b0;
  logic [31:0] mv_src, mv_dst;
  logic [1:0]  mv_size;
  logic [10:0] remaining;
  logic        active, err, irq_a, irq_b;

  logic [31:0] mem [256];
  assign mem_rvalid = mem_req;
  assign mem_rdata  = mem[mem_addr[9:2]];

  always #5 clk = ~clk;

  dma_chain_seq dut (.*);

  int n_chk = 0, n_fail = 0;
  int ntx = 0, nia = 0, nib = 0, nreq = 0;
  logic [31:0] lsrc [16];
  logic [31:0] ldst [16];
  logic [1:0]  lsz  [16];
  logic [31:0] last_src, last_dst;
  logic [31:0] raddr [8];

  always @(posedge clk) begin
    mv_done <= mv_go && !mv_done;
    if (mv_go && mv_done) begin
      if (ntx < 16) begin lsrc[ntx] <= mv_src; ldst[ntx] <= mv_dst; lsz[ntx] <= mv_size; end
      last_src <= mv_src; last_dst <= mv_dst;
      ntx <= ntx + 1;
    end
    if (mem_req) begin
      if (nreq < 8) raddr[nreq] <= mem_addr;
      nreq <= nreq + 1;
    end
    if (irq_a) nia <= nia + 1;
    if (irq_b) nib <= nib + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(bit v, bit rl, bit ia, bit ib,
      int wsz, int sic, int dic, int n);
    logic [31:0] c = '0;
    c[0] = v; c[1] = rl; c[2] = ia; c[3] = ib;
    c[5:4] = 2'(wsz); c[7:6] = 2'(sic); c[9:8] = 2'(dic);
    c[25:16] = 10'(n - 1);
    return c;
  endfunction

  function automatic int incf(int code);
    return (code == 3) ? 4 : code;
  endfunction

  function automatic logic [31:0] first_addr(logic [31:0] e, int n, int inc_code, int wsz);
    return e - 32'((n - 1) * incf(inc_code) * (1 << wsz));
  endfunction

  task automatic put_desc(int base, logic [31:0] c, logic [31:0] s, logic [31:0] d, logic [31:0] l);
    mem[base/4] = c; mem[base/4+1] = s; mem[base/4+2] = d; mem[base/4+3] = l;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    ntx = 0; nia = 0; nib = 0; nreq = 0;
  endtask

  task automatic kick(logic [31:0] a);
    start_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(int limit);
    for (int i = 0; i < limit && active; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!active && !err && !mem_req && !mv_go && remaining == 0 && !irq_a && !irq_b,
        "R11 reset state", {active, err, mem_req, mv_go}, 0);
  endtask

  task automatic t_single();
    logic [31:0] c = mkcfg(1, 0, 1, 0, 2, 1, 1, 4);
    put_desc(32'h10, c, 32'h10C, 32'h20C, 32'h0);
    clear_logs();
    kick(32'h10);
    chk(active, "R11 active after start", active, 1);
    wait_idle(100);
    chk(nreq == 4, "R1 four reads", nreq, 4);
    for (int i = 0; i < 4; i++)
      chk(raddr[i] == 32'h10 + 32'(4*i), "R1 read address", raddr[i], 32'h10 + 4*i);
    chk(ntx == 4, "R3 unit count", ntx, 4);
    for (int i = 0; i < 4; i++) begin
      chk(lsrc[i] == 32'h100 + 32'(4*i), "R5 source address", lsrc[i], 32'h100 + 4*i);
      chk(ldst[i] == 32'h200 + 32'(4*i), "R5 dest address", ldst[i], 32'h200 + 4*i);
      chk(lsz[i] == 2'd2, "R4 size code", lsz[i], 2);
    end
    chk(nia == 1 && nib == 0, "R8 irq A only", {nia[7:0], nib[7:0]}, 16'h0100);
    chk(!active && remaining == 0, "R7 stop without reload", {active, remaining}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] c1 = mkcfg(1, 1, 0, 0, 1, 0, 2, 3);
    logic [31:0] c2 = mkcfg(1, 0, 0, 1, 0, 3, 0, 2);
    logic [31:0] ds = first_addr(32'h300, 3, 2, 1);
    logic [31:0] ss = first_addr(32'h410, 2, 3, 0);
    put_desc(32'h40, c1, 32'h200, 32'h300, 32'h80);
    put_desc(32'h80, c2, 32'h410, 32'h500, 32'h0);
    clear_logs();
    kick(32'h40);
    wait_idle(100);
    chk(ntx == 5, "R7 chained unit count", ntx, 5);
    for (int i = 0; i < 3; i++) begin
      chk(lsrc[i] == 32'h200, "R4 fixed source", lsrc[i], 32'h200);
      chk(ldst[i] == ds + 32'(4*i), "R5 dest step 2 units of 2B", ldst[i], ds + 4*i);
      chk(lsz[i] == 2'd1, "R4 size code 1", lsz[i], 1);
    end
    for (int i = 0; i < 2; i++) begin
      chk(lsrc[3+i] == ss + 32'(4*i), "R5 source step 4 units of 1B", lsrc[3+i], ss + 4*i);
      chk(ldst[3+i] == 32'h500, "R4 fixed dest", ldst[3+i], 32'h500);
    end
    chk(raddr[4] == 32'h80, "R7 link fetch", raddr[4], 32'h80);
    chk(nia == 0 && nib == 1, "R8 irq B only", {nia[7:0], nib[7:0]}, 16'h0001);
  endtask

  task automatic t_invalid();
    put_desc(32'hC0, mkcfg(0, 1, 1, 1, 0, 1, 1, 4), 32'h0, 32'h0, 32'h40);
    clear_logs();
    kick(32'hC0);
    wait_idle(20);
    chk(ntx == 0 && nreq == 4, "R2 invalid issues nothing", ntx, 0);
    chk(!err && !active && nia == 0 && nib == 0, "R2 no error, inactive", {err, active}, 0);
  endtask

  task automatic t_misalign();
    put_desc(32'hD0, mkcfg(1, 0, 1, 0, 2, 1, 1, 2), 32'h102, 32'h200, 32'h0);
    clear_logs();
    kick(32'hD0);
    wait_idle(20);
    chk(err && !active && ntx == 0, "R9 misaligned 4B", {err, active, 8'(ntx)}, 10'h200);
    repeat (3) @(negedge clk);
    chk(err, "R9 error held", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!err, "R9 error cleared", err, 0);
    put_desc(32'hD0, mkcfg(1, 0, 0, 0, 3, 1, 1, 2), 32'h100, 32'h200, 32'h0);
    clear_logs();
    kick(32'hD0);
    wait_idle(20);
    chk(err && ntx == 0, "R9 width code 3", {err, 8'(ntx)}, 9'h100);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_abort();
    put_desc(32'hE0, mkcfg(1, 1, 1, 1, 0, 1, 1, 10), 32'h109, 32'h209, 32'hE0);
    clear_logs();
    kick(32'hE0);
    for (int i = 0; i < 100 && ntx < 3; i++) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(active, "R10 in-flight unit finishes", active, 1);
    @(negedge clk);
    chk(!active, "R10 inactive after done", active, 0);
    repeat (4) @(negedge clk);
    chk(ntx == 4, "R10 one more unit only", ntx, 4);
    chk(remaining == 6, "R10 remaining kept", remaining, 6);
    chk(nia == 0 && nib == 0 && nreq == 4, "R10 no irq no reload", nreq, 4);
    clear_logs();
    kick(32'hE0);
    @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!active, "R10 abort during fetch", active, 0);
  endtask

  task automatic t_max();
    put_desc(32'hF0, mkcfg(1, 0, 0, 1, 0, 1, 1, 1024), 32'h13FF, 32'h23FF, 32'h0);
    clear_logs();
    kick(32'hF0);
    for (int i = 0; i < 20 && !mv_go; i++) @(negedge clk);
    chk(remaining == 1024, "R3 full count 1024", remaining, 1024);
    for (int i = 0; i < 3000 && ntx < 500; i++) @(negedge clk);
    chk(remaining == 11'(1024 - ntx), "R3 remaining tracks units", remaining, 1024 - ntx);
    wait_idle(3000);
    chk(ntx == 1024, "R3 max units", ntx, 1024);
    chk(lsrc[0] == 32'h1000 && ldst[0] == 32'h2000, "R5 first at end minus span", lsrc[0], 32'h1000);
    chk(last_src == 32'h13FF && last_dst == 32'h23FF, "R5 last at end", last_src, 32'h13FF);
    chk(nib == 1, "R8 irq B at end", nib, 1);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_invalid();
    t_misalign();
    t_abort();
    t_max();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule